// File: doc/BRIEF.md
# Interval Timer Channel with System Control Port

This block is one down-counting channel of a legacy PC-style interval timer. It has a control-word decoder and a small system control port. A byte-wide host bus reaches it through three I/O offsets: a counter data port, a mode/control port and a system control port. The default offsets are 0x42, 0x43 and 0x61.

Software programs the channel with a packed control word and then loads the 16-bit count. The count is loaded as one byte or as a low byte followed by a high byte. The channel counts down on clock edges where the tick enable is high, which stands in for a nominal 1193180 Hz time base. The channel output reports terminal count.

The gate and the speaker-enable bit are stored in the system control port. A read of that port also returns the live channel output. Software typically loads a count, raises the gate, and polls the output bit of the system port until it goes high.

Only interrupt-on-terminal-count operation with binary counting is implemented. The decoder recognises control words for other channels, other modes, BCD counting and read-back, and leaves the channel untouched when it sees them.

Top module: `pit_channel`

## Requirements
- R1: A control-port write whose bits 7:6 are not 10 has no effect on the channel. Bits 7:6 of 00 or 01 address other channels, and 11 is read-back. After such a write, the output and the byte sequence are unchanged.
- R2: A channel-2 control word is ignored when it carries a non-latch access type (bits 5:4 not 00) together with either a mode field (bits 3:1) other than 000 or a BCD bit (bit 0) of 1.
- R3: An accepted channel-2 control word has bits 5:4 nonzero, bits 3:1 = 000 and bit 0 = 0. It drives the output low by the next cycle, stops counting, and resets the write byte pointer, so the next data write is taken as the low byte.
- R4: In word access (bits 5:4 = 11), the first data write is the low byte and the second data write is the high byte. Counting starts only after the high byte is written. While only the low byte is held, ticks do not change the output.
- R5: In low-only access (01), a single data write loads the low byte with the high byte cleared. In high-only access (10), a single data write loads the high byte with the low byte cleared. In both cases counting starts at once.
- R6: A loaded count N (N ≥ 1) decrements on each clock edge where tick_i and the gate are both high. The output rises on the edge of the N-th such tick.
- R7: Once high, the output stays high until the next accepted control word or the next data write.
- R8: While the gate is low, the count holds its value and the output does not rise.
- R9: A channel-2 control word with bits 5:4 = 00 takes a snapshot of the count. The next two data-port reads return the snapshot's low byte and then its high byte; after that, reads return the live count. The snapshot command changes neither the output nor the loaded configuration.
- R10: A data-port read without a snapshot pending returns the live count: in word access the low byte and the high byte in turn, starting with the low byte; in low-only access always the low byte; in high-only access always the high byte.
- R11: A system-port write stores bit 0 as the gate and bit 1 as the speaker enable, and ignores all other bits. A read returns the live output in bit 5, the stored bits in bits 1:0, and zero in every other bit.
- R12: After reset the output is low, the gate and the speaker enable are low, the count is zero, and the channel is in word access and not counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 16 | I/O address of the access |
| bus_wr_i | input | 1 | Write strobe, one cycle per byte |
| bus_rd_i | input | 1 | Read strobe, one cycle per byte |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the cycle of bus_rd_i |
| tick_i | input | 1 | Count enable from the time base |
| out_o | output | 1 | Channel output, high at terminal count |
| gate_o | output | 1 | Stored gate bit |
| spk_o | output | 1 | Stored speaker-enable bit |

## Verification
A wrong byte pointer shows at the ports as a count loaded with its bytes swapped or never started. The output then rises many ticks late or not at all, and a data read in the cycle after the load returns the wrong byte. A wrong armed state or gate handling shows on the exact tick where the output should rise: a rise one tick early or late marks a decrement-path fault, and a rise while the gate is low marks a gate fault. A snapshot or read-pointer fault appears within two data reads as a byte that differs from the count at the time of the snapshot.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_WORD = 2'b11
  } access_e;

  typedef struct packed {
    logic [1:0] sel;
    access_e    acc;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_word_t;

endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
  import pit_pkg::*;
#(
  parameter logic [1:0] CHAN = 2'd2
) (
  input  logic [7:0] cw_i,
  output logic       prog_o,
  output logic       snap_o,
  output access_e    acc_o
);

  ctrl_word_t cw;
  logic       hit;
  logic       supported;

  assign cw        = ctrl_word_t'(cw_i);
  assign hit       = (cw.sel == CHAN);
  // only interrupt-on-terminal-count with binary counting is built
  assign supported = (cw.mode == 3'd0) && !cw.bcd;
  assign snap_o    = hit && (cw.acc == ACC_SNAP);
  assign prog_o    = hit && (cw.acc != ACC_SNAP) && supported;
  assign acc_o     = cw.acc;

endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  access_e           prog_acc_i,
  input  logic              snap_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              gate_i,
  input  logic              tick_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              out_o
);

  localparam int CNT_W = 2 * BYTE_W;

  access_e           acc_q;
  logic              wr_hi_q, rd_hi_q, armed_q, out_q, snapped_q;
  logic [CNT_W-1:0]  cnt_q, snap_q;
  logic [BYTE_W-1:0] lo_buf_q;
  logic              run;
  logic              term;

  assign run  = armed_q && gate_i && tick_i;
  assign term = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= ACC_WORD;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      armed_q   <= 1'b0;
      out_q     <= 1'b0;
      snapped_q <= 1'b0;
      cnt_q     <= '0;
      snap_q    <= '0;
      lo_buf_q  <= '0;
    end else if (prog_i) begin
      acc_q     <= prog_acc_i;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      armed_q   <= 1'b0;
      out_q     <= 1'b0;
      snapped_q <= 1'b0;
    end else if (snap_i) begin
      if (!snapped_q) begin
        snap_q    <= cnt_q;
        snapped_q <= 1'b1;
        rd_hi_q   <= 1'b0;
      end
    end else if (wr_i) begin
      unique case (acc_q)
        ACC_LO: begin
          cnt_q   <= {{BYTE_W{1'b0}}, wdata_i};
          armed_q <= 1'b1;
          out_q   <= 1'b0;
        end
        ACC_HI: begin
          cnt_q   <= {wdata_i, {BYTE_W{1'b0}}};
          armed_q <= 1'b1;
          out_q   <= 1'b0;
        end
        ACC_WORD: begin
          if (!wr_hi_q) begin
            lo_buf_q <= wdata_i;
            wr_hi_q  <= 1'b1;
            armed_q  <= 1'b0;
            out_q    <= 1'b0;
          end else begin
            cnt_q   <= {wdata_i, lo_buf_q};
            wr_hi_q <= 1'b0;
            armed_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end else begin
      if (run) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (term) out_q <= 1'b1;
      end
      if (rd_i) begin
        if (snapped_q) begin
          if (rd_hi_q) snapped_q <= 1'b0;
          rd_hi_q <= ~rd_hi_q;
        end else if (acc_q == ACC_WORD) begin
          rd_hi_q <= ~rd_hi_q;
        end
      end
    end
  end

  logic             sel_hi;
  logic [CNT_W-1:0] src;

  always_comb begin
    src    = snapped_q ? snap_q : cnt_q;
    sel_hi = snapped_q ? rd_hi_q
                       : (acc_q == ACC_HI) || ((acc_q == ACC_WORD) && rd_hi_q);
    rdata_o = sel_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
  end

  assign out_o = out_q;

endmodule

// File: rtl/pit_sys_port.sv
module pit_sys_port #(
  parameter int GATE_BIT = 0,
  parameter int SPK_BIT  = 1,
  parameter int OUT_BIT  = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       out_i,
  output logic       gate_o,
  output logic       spk_o,
  output logic [7:0] rdata_o
);

  logic gate_q, spk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      spk_q  <= 1'b0;
    end else if (wr_i) begin
      gate_q <= wdata_i[GATE_BIT];
      spk_q  <= wdata_i[SPK_BIT];
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[GATE_BIT] = gate_q;
    rdata_o[SPK_BIT]  = spk_q;
    rdata_o[OUT_BIT]  = out_i;
  end

  assign gate_o = gate_q;
  assign spk_o  = spk_q;

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'('h42),
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('h43),
  parameter logic [ADDR_W-1:0] SYS_ADDR  = ADDR_W'('h61)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              tick_i,
  output logic              out_o,
  output logic              gate_o,
  output logic              spk_o
);

  logic       hit_data, hit_ctrl, hit_sys;
  logic       cw_prog, cw_snap;
  access_e    cw_acc;
  logic [7:0] cnt_rdata, sys_rdata;
  logic       chan_out;

  assign hit_data = (bus_addr_i == DATA_ADDR);
  assign hit_ctrl = (bus_addr_i == CTRL_ADDR);
  assign hit_sys  = (bus_addr_i == SYS_ADDR);

  pit_ctrl_decode #(.CHAN(2'd2)) u_dec (
    .cw_i   (bus_wdata_i),
    .prog_o (cw_prog),
    .snap_o (cw_snap),
    .acc_o  (cw_acc)
  );

  pit_counter #(.BYTE_W(8)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prog_i     (bus_wr_i && hit_ctrl && cw_prog),
    .prog_acc_i (cw_acc),
    .snap_i     (bus_wr_i && hit_ctrl && cw_snap),
    .wr_i       (bus_wr_i && hit_data),
    .wdata_i    (bus_wdata_i),
    .rd_i       (bus_rd_i && hit_data),
    .gate_i     (gate_o),
    .tick_i     (tick_i),
    .rdata_o    (cnt_rdata),
    .out_o      (chan_out)
  );

  pit_sys_port u_sys (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bus_wr_i && hit_sys),
    .wdata_i (bus_wdata_i),
    .out_i   (chan_out),
    .gate_o  (gate_o),
    .spk_o   (spk_o),
    .rdata_o (sys_rdata)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (hit_data)     bus_rdata_o = cnt_rdata;
    else if (hit_sys) bus_rdata_o = sys_rdata;
  end

  assign out_o = chan_out;

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('h43),
  parameter logic [ADDR_W-1:0] SYS_ADDR  = ADDR_W'('h61)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic [7:0]        bus_wdata_i,
  input logic              tick_i,
  input logic              out_o,
  input logic              gate_o,
  input logic              spk_o
);

  logic cw_wr;
  assign cw_wr = bus_wr_i && (bus_addr_i == CTRL_ADDR);

  AST_FOREIGN_CW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_wr && (bus_wdata_i[7:6] != 2'b10) && !tick_i |=> $stable(out_o)); // R1

  AST_UNSUP_CW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_wr && (bus_wdata_i[7:6] == 2'b10) && (bus_wdata_i[5:4] != 2'b00)
    && (bus_wdata_i[3:0] != 4'h0) && !tick_i |=> $stable(out_o)); // R2

  AST_PROG_CLEARS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_wr && (bus_wdata_i[7:6] == 2'b10) && (bus_wdata_i[5:4] != 2'b00)
    && (bus_wdata_i[3:0] == 4'h0) |=> !out_o); // R3

  AST_RISE_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_o) |-> $past(tick_i && gate_o && !bus_wr_i)); // R6

  AST_OUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_o) |-> $past(bus_wr_i)); // R7

  AST_GATE_LOW_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_o |=> !$rose(out_o)); // R8

  AST_SYS_BITS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && (bus_addr_i == SYS_ADDR)) |=> $stable({gate_o, spk_o})); // R11

endmodule

bind pit_channel pit_channel_chk #(
  .ADDR_W    (ADDR_W),
  .CTRL_ADDR (CTRL_ADDR),
  .SYS_ADDR  (SYS_ADDR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .tick_i      (tick_i),
  .out_o       (out_o),
  .gate_o      (gate_o),
  .spk_o       (spk_o)
);

// File: tb/pit_channel_bench.sv
module pit_channel_bench;

  localparam int CLK_P = 10;
  localparam logic [15:0] A_DATA = 16'h0042;
  localparam logic [15:0] A_CTRL = 16'h0043;
  localparam logic [15:0] A_SYS  = 16'h0061;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0, tick = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        out, gate, spk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  string      q_req[$];
  int         q_sel[$];
  logic [7:0] q_val[$];

  always #(CLK_P/2) clk = ~clk;

  pit_channel u_pit_channel (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .tick_i      (tick),
    .out_o       (out),
    .gate_o      (gate),
    .spk_o       (spk)
  );

  // sel: 0 = read data, 1 = out, 2 = gate, 3 = speaker
  task automatic push(input string req, input int sel, input logic [7:0] val);
    q_req.push_back(req);
    q_sel.push_back(sel);
    q_val.push_back(val);
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    tick = 1'b0; rd = 1'b0; wr = 1'b1; addr = a; wdata = d;
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    tick = 1'b0; wr = 1'b0; rd = 1'b1; addr = a;
    push(req, 0, exp);
  endtask

  task automatic chk_out(input logic exp, input string req);
    @(negedge clk);
    tick = 1'b0; wr = 1'b0; rd = 1'b0;
    push(req, 1, {7'd0, exp});
  endtask

  task automatic tick_chk(input logic exp, input string req);
    @(negedge clk);
    tick = 1'b1; wr = 1'b0; rd = 1'b0;
    push(req, 1, {7'd0, exp});
  endtask

  task automatic tick_n(input int n);
    repeat (n) begin
      @(negedge clk);
      tick = 1'b1; wr = 1'b0; rd = 1'b0;
    end
  endtask

  // monitor: pops expectations a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (q_val.size() > 0) begin
        string      r;
        int         s;
        logic [7:0] e, a;
        r = q_req.pop_front();
        s = q_sel.pop_front();
        e = q_val.pop_front();
        case (s)
          0:       a = rdata;
          1:       a = {7'd0, out};
          2:       a = {7'd0, gate};
          default: a = {7'd0, spk};
        endcase
        n_chk++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%02h expected=%02h at %0t", r, s, a, e, $time);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    chk_out(1'b0, "R12");
    bus_rd(A_SYS, 8'h00, "R12");
    bus_rd(A_DATA, 8'h00, "R12");
    bus_rd(A_DATA, 8'h00, "R12");

    // R11 gate and speaker set, bit 5 write ignored
    bus_wr(A_SYS, 8'hFF);
    bus_rd(A_SYS, 8'h03, "R11");

    // R4 word load; ticks before high byte do nothing
    bus_wr(A_CTRL, 8'hB0);
    bus_wr(A_DATA, 8'h05);
    tick_n(3);
    bus_wr(A_DATA, 8'h00);
    for (int i = 0; i <= 7; i++) tick_chk(i >= 5, (i < 6) ? "R4" : "R7");

    // R8 gate low holds count
    bus_wr(A_CTRL, 8'hB0);
    bus_wr(A_DATA, 8'h03);
    bus_wr(A_SYS, 8'h00);
    bus_wr(A_DATA, 8'h00);
    for (int i = 0; i < 10; i++) tick_chk(1'b0, "R8");
    bus_rd(A_DATA, 8'h03, "R8");
    bus_rd(A_DATA, 8'h00, "R10");
    bus_wr(A_SYS, 8'h01);
    for (int i = 0; i <= 3; i++) tick_chk(i >= 3, "R6");

    // R3 control word drops output and resets byte pointer
    bus_wr(A_CTRL, 8'hB0);
    chk_out(1'b0, "R3");
    bus_wr(A_DATA, 8'h07);
    bus_wr(A_CTRL, 8'hB0);
    bus_wr(A_DATA, 8'h02);
    bus_wr(A_DATA, 8'h00);
    for (int i = 0; i <= 2; i++) tick_chk(i >= 2, "R3");

    // R5 low-only access, R10 read returns low byte each time
    bus_wr(A_CTRL, 8'h90);
    bus_wr(A_DATA, 8'h04);
    bus_rd(A_DATA, 8'h04, "R10");
    bus_rd(A_DATA, 8'h04, "R10");
    for (int i = 0; i <= 4; i++) tick_chk(i >= 4, "R5");

    // R5 high-only access: count 256
    bus_wr(A_CTRL, 8'hA0);
    bus_wr(A_DATA, 8'h01);
    bus_rd(A_DATA, 8'h01, "R10");
    tick_n(255);
    chk_out(1'b0, "R5");
    tick_chk(1'b0, "R5");
    chk_out(1'b1, "R5");

    // R9 snapshot
    bus_wr(A_CTRL, 8'hB0);
    bus_wr(A_DATA, 8'h10);
    bus_wr(A_DATA, 8'h00);
    tick_n(4);
    bus_wr(A_CTRL, 8'h80);
    tick_n(3);
    bus_rd(A_DATA, 8'h0C, "R9");
    bus_rd(A_DATA, 8'h00, "R9");
    bus_rd(A_DATA, 8'h09, "R9");
    bus_rd(A_DATA, 8'h00, "R10");
    chk_out(1'b0, "R9");

    // R1 / R2 ignored control words between the two load bytes
    bus_wr(A_CTRL, 8'hB0);
    bus_wr(A_DATA, 8'h03);
    bus_wr(A_CTRL, 8'h30);
    bus_wr(A_CTRL, 8'h70);
    bus_wr(A_CTRL, 8'hC2);
    bus_wr(A_DATA, 8'h00);
    for (int i = 0; i <= 3; i++) tick_chk(i >= 3, "R1");
    bus_wr(A_CTRL, 8'h70);
    chk_out(1'b1, "R1");

    bus_wr(A_CTRL, 8'hB0);
    bus_wr(A_DATA, 8'h02);
    bus_wr(A_CTRL, 8'hB4);
    bus_wr(A_CTRL, 8'hB1);
    bus_wr(A_DATA, 8'h00);
    for (int i = 0; i <= 2; i++) tick_chk(i >= 2, "R2");
    bus_wr(A_CTRL, 8'hB2);
    chk_out(1'b1, "R2");

    // R11 other bits ignored, bit 5 reflects live output
    bus_wr(A_SYS, 8'hDE);
    bus_rd(A_SYS, 8'h22, "R11");
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    push("R11", 2, 8'h00);
    push("R11", 3, 8'h01);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule